// File: doc/BRIEF.md
# Thermometer-to-Binary Transition Decoder

This block turns the tap vector of a flash quantiser into a level number. It works in two registered stages. The first stage scans the taps for the single place where the code falls from ones to zeros. It marks that place in a one-hot row vector, with one row for each level from 0 to 2^N − 1. The second stage turns the active row into the output word. It uses one OR tree per output bit, and each tree's mask is computed at elaboration from the row's code. A parameter fixes the row codes as plain binary or as reflected Gray.

The transition test looks at four neighbouring taps. These are two taps at or below the candidate row, which must read one, and two taps above it, which must read zero. Virtual taps fill the window at both ends: the taps below tap 1 read one and the taps above the top tap read zero. So an all-zero input selects row 0. A single tap that disagrees with both neighbours on its side of the transition cannot open a second row, so such a bubble leaves the result at the clean level. A separate flag reports when two or more rows still fire after this gating. It is meant for the consumer of the code, so that it can discard a corrupted sample.

Top module: `thermo_transition_decoder`

## Requirements
- R1: Input bit i of `therm_in` is tap i+1. A clean code for level k has taps 1..k at one and all other taps at zero. Each output reflects the input sampled two rising clock edges earlier.
- R2: With `GRAY_OUT` = 0, a clean code for level k gives `code_out` = k and `multi_row_out` = 0.
- R3: With `GRAY_OUT` = 1, a clean code for level k gives `code_out` = k XOR (k >> 1) and `multi_row_out` = 0.
- R4: An all-zero input gives code 0. An all-ones input gives the top level 2^N − 1 (its Gray form 2^(N-1) in Gray mode).
- R5: A clean level-k code with one extra 1 at tap j, where j ≥ k+3, gives the same code as level k, and the flag stays low.
- R6: A clean level-k code with one tap j cleared, where j ≤ k−2, gives the same code as level k, and the flag stays low.
- R7: When no row satisfies the transition test (for example level k plus an extra 1 at tap k+2), `code_out` is 0 and the flag is low.
- R8: When two or more rows fire, `multi_row_out` is 1 and `code_out` is the bitwise OR of their codes. For N = 4, taps 1,2,5,6 set gives rows 2 and 6: binary 6, Gray 7.
- R9: While the synchronous active-high `rst` is sampled high, and in the cycle after it, `code_out` is 0 and `multi_row_out` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| therm_in | input | 2^BITS − 1 | Tap vector, bit i is tap i+1 |
| code_out | output | BITS | Registered level code (binary or Gray) |
| multi_row_out | output | 1 | Registered flag: two or more rows fired |

## Verification
The assertions check on every cycle these behaviours:
- Any clean thermometer input produces exactly the matching row one cycle later, and the correct code two cycles later, with the flag low.
- An empty row vector yields a zero code.
- The flag tracks whether more than one row was held.
- Reset clears both outputs.

Only the bench's scenarios can show two things. The first is that bubbles at least two taps from the transition leave the level unchanged. The second is the exact values in the no-row and two-row cases. Each needs a specific malformed input pattern and a value worked out by hand.

// File: rtl/thermo_dec_pkg.sv
package thermo_dec_pkg;

  // Code carried by row m: plain binary or reflected Gray
  function automatic int unsigned row_code(input int unsigned m, input bit gray);
    return gray ? (m ^ (m >> 1)) : m;
  endfunction

  // True when v has the form 0...01...1 (a clean thermometer code)
  function automatic bit is_thermo(input logic [63:0] v);
    return (v & (v + 64'd1)) == 64'd0;
  endfunction

endpackage

// File: rtl/therm_row_select.sv
module therm_row_select #(
  parameter int TAPS = 15,
  parameter int ROWS = TAPS + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [TAPS-1:0] therm_i,
  output logic [ROWS-1:0] row_q
);
  import thermo_dec_pkg::*;

  localparam int EXT_W = TAPS + 4;

  // ext[t+1] holds tap t; taps -1 and 0 read one, taps TAPS+1 and TAPS+2 read zero
  logic [EXT_W-1:0] ext;
  logic [ROWS-1:0]  hit;

  assign ext = {2'b00, therm_i, 2'b11};

  for (genvar m = 0; m < ROWS; m++) begin : g_row
    // taps m-1 and m high, taps m+1 and m+2 low
    assign hit[m] = ext[m] & ext[m+1] & ~ext[m+2] & ~ext[m+3];
  end

  always_ff @(posedge clk) begin
    if (rst) row_q <= '0;
    else     row_q <= hit;
  end

  AST_CLEAN_ONE_ROW: assert property (@(posedge clk) disable iff (rst)
    is_thermo(64'(therm_i)) |=> row_q == (ROWS'(1) << $countones($past(therm_i)))); // R2

endmodule

// File: rtl/row_code_encoder.sv
module row_code_encoder #(
  parameter int BITS     = 4,
  parameter int ROWS     = 1 << BITS,
  parameter bit GRAY_OUT = 1'b0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [ROWS-1:0] row_i,
  output logic [BITS-1:0] code_q,
  output logic            multi_q
);
  import thermo_dec_pkg::*;

  function automatic logic [ROWS-1:0] bit_mask(input int b);
    logic [ROWS-1:0] mk;
    for (int m = 0; m < ROWS; m++) begin
      mk[m] = ((row_code(m, GRAY_OUT) >> b) & 1) != 0;
    end
    return mk;
  endfunction

  logic [BITS-1:0] code_d;
  logic [ROWS-2:0] seen;
  logic [ROWS-1:0] dup;

  // One OR tree per output bit over the rows whose code has that bit set
  for (genvar b = 0; b < BITS; b++) begin : g_bit
    localparam logic [ROWS-1:0] MASK = bit_mask(b);
    assign code_d[b] = |(row_i & MASK);
  end

  // Prefix chain: dup rises once a second active row is met
  assign seen[0] = row_i[0];
  assign dup[0]  = 1'b0;
  for (genvar m = 1; m < ROWS; m++) begin : g_chain
    assign dup[m] = dup[m-1] | (seen[m-1] & row_i[m]);
    if (m < ROWS - 1) begin : g_seen
      assign seen[m] = seen[m-1] | row_i[m];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q  <= '0;
      multi_q <= 1'b0;
    end else begin
      code_q  <= code_d;
      multi_q <= dup[ROWS-1];
    end
  end

  AST_EMPTY_ROWS: assert property (@(posedge clk) disable iff (rst)
    (row_i == '0) |=> (code_q == '0) && !multi_q); // R7

  AST_MULTI_FLAG: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> multi_q == ($countones($past(row_i)) > 1)); // R8

endmodule

// File: rtl/thermo_transition_decoder.sv
module thermo_transition_decoder #(
  parameter int BITS     = 4,
  parameter bit GRAY_OUT = 1'b0
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [(1<<BITS)-2:0]   therm_in,
  output logic [BITS-1:0]        code_out,
  output logic                   multi_row_out
);
  import thermo_dec_pkg::*;

  localparam int ROWS = 1 << BITS;
  localparam int TAPS = ROWS - 1;

  logic [ROWS-1:0] rows;

  therm_row_select #(.TAPS(TAPS), .ROWS(ROWS)) u_select (
    .clk     (clk),
    .rst     (rst),
    .therm_i (therm_in),
    .row_q   (rows)
  );

  row_code_encoder #(.BITS(BITS), .ROWS(ROWS), .GRAY_OUT(GRAY_OUT)) u_encode (
    .clk     (clk),
    .rst     (rst),
    .row_i   (rows),
    .code_q  (code_out),
    .multi_q (multi_row_out)
  );

  // Cycles since reset release, saturating at two (assertion window only)
  logic [1:0] settle_q;
  always_ff @(posedge clk) begin
    if (rst)                 settle_q <= 2'd0;
    else if (settle_q != 2'd2) settle_q <= settle_q + 2'd1;
  end

  AST_CLEAN_CODE: assert property (@(posedge clk) disable iff (rst)
    (settle_q == 2'd2 && is_thermo(64'($past(therm_in, 2))))
    |-> (code_out == BITS'(row_code($countones($past(therm_in, 2)), GRAY_OUT)))
        && !multi_row_out); // R3

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (code_out == '0) && !multi_row_out); // R9

endmodule

// File: tb/thermo_transition_decoder_tb_top.sv
`timescale 1ns/1ps
module thermo_transition_decoder_tb_top;
  localparam int BITS = 4;
  localparam int TAPS = (1 << BITS) - 1;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [TAPS-1:0] therm = '0;
  logic [BITS-1:0] code_b, code_g;
  logic            flag_b, flag_g;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  thermo_transition_decoder #(.BITS(BITS), .GRAY_OUT(1'b0)) dut_i (
    .clk(clk), .rst(rst), .therm_in(therm), .code_out(code_b), .multi_row_out(flag_b));

  thermo_transition_decoder #(.BITS(BITS), .GRAY_OUT(1'b1)) dut_gray_i (
    .clk(clk), .rst(rst), .therm_in(therm), .code_out(code_g), .multi_row_out(flag_g));

  function automatic int gray_of(input int k);
    return k ^ (k >> 1);
  endfunction

  function automatic logic [TAPS-1:0] clean(input int k);
    return TAPS'((1 << k) - 1);
  endfunction

  task automatic check(input int act, input int exp, input string req, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Drive on a falling edge; rows load at the next rising edge, outputs one edge later
  task automatic run_case(input logic [TAPS-1:0] v, input int eb, input int eg,
                          input bit ef, input string req);
    @(negedge clk);
    therm = v;
    @(negedge clk);
    @(negedge clk);
    check(int'(code_b), eb, req, "binary code");
    check(int'(code_g), eg, req, "gray code");
    check(int'(flag_b), int'(ef), req, "binary flag");
    check(int'(flag_g), int'(ef), req, "gray flag");
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #1_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h1d2c_3b4a));
    therm = clean(9);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: outputs clear during reset
    check(int'(code_b), 0, "R9", "reset code");
    check(int'(flag_b), 0, "R9", "reset flag");
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(int'(code_b), 0, "R9", "first cycle after reset");

    // R4 boundaries
    run_case('0, 0, 0, 1'b0, "R4");
    run_case('1, TAPS, gray_of(TAPS), 1'b0, "R4");

    // R2 / R3 every clean level (R1 timing in run_case)
    for (int k = 0; k <= TAPS; k++) begin
      run_case(clean(k), k, gray_of(k), 1'b0, "R2_R3_R1");
    end

    // R5 / R6 every single flip two or more taps from the transition
    for (int k = 0; k <= TAPS; k++) begin
      for (int j = 1; j <= TAPS; j++) begin
        if (j >= k + 3) run_case(clean(k) ^ TAPS'(1 << (j-1)), k, gray_of(k), 1'b0, "R5");
        else if (j <= k - 2) run_case(clean(k) ^ TAPS'(1 << (j-1)), k, gray_of(k), 1'b0, "R6");
      end
    end

    // R7 no row fires: level 5 plus extra 1 at tap 7
    run_case(clean(5) | TAPS'(1 << 6), 0, 0, 1'b0, "R7");
    // R7 level 0 plus tap 2
    run_case(TAPS'(1 << 1), 0, 0, 1'b0, "R7");

    // R8 two rows: taps 1,2,5,6 -> rows 2 and 6
    run_case(TAPS'(16'b0000_0000_0011_0011), 6, 7, 1'b1, "R8");
    // R8 rows 3 and 12: taps 1..3 and 11,12
    run_case(TAPS'(16'b0000_1100_0000_0111), 3 | 12, gray_of(3) | gray_of(12), 1'b1, "R8");

    // Random mix of clean codes and distant bubbles
    for (int n = 0; n < 300; n++) begin
      int k, j;
      k = int'($urandom_range(0, TAPS));
      j = int'($urandom_range(1, TAPS));
      if (j >= k + 3)      run_case(clean(k) ^ TAPS'(1 << (j-1)), k, gray_of(k), 1'b0, "R5");
      else if (j <= k - 2) run_case(clean(k) ^ TAPS'(1 << (j-1)), k, gray_of(k), 1'b0, "R6");
      else                 run_case(clean(k), k, gray_of(k), 1'b0, "R2");
    end

    // R9 reset mid-stream
    @(negedge clk);
    therm = '1;
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(int'(code_b), 0, "R9", "reset mid-stream");
    check(int'(flag_g), 0, "R9", "reset mid-stream flag");
    rst = 1'b0;

    finish_run();
  end
endmodule